// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the network-layer controller of a single-wire bus slave. After each bus reset and presence exchange, it takes in one 8-bit ROM command from the master. It then runs that command against the device's 64-bit identity. The command can read the identity out, compare it with an identity the master sends, take part in a bit-wise search among several slaves, skip addressing, or re-select the last addressed device through a resume flag. When a command succeeds, the block raises a select output, and the memory-function layer takes over the bus until the next bus reset.

The block sits above a bit-level link layer, which handles all analog timing. For each time slot the link layer gives one strobe and the sampled bus level. Between slots the block states whether the coming slot is a transmit slot and which level it sends. A transmitted 0 means the line is driven low. A transmitted 1 means the line is released. The identity is assembled from a fixed family code, a serial number input and a CRC that the block computes over those 56 bits.

Top module: `rom_cmd_layer`

## Requirements
- R1: After rst_ni is released, tx_active_o=0, tx_bit_o=1, mem_sel_o=0 and resume_o=0. Slot strobes are ignored until the first bus_reset_i.
- R2: The identity is sent least significant bit first. Bits 7:0 hold the family code (default 2Dh). Bits 55:8 hold serial_i. Bits 63:56 hold a CRC of bits 55:0, computed as follows: start from 00h, feed the bits LSB first, and for each bit shift the CRC right, XOR-ing 8Ch in whenever crc[0] XOR bit was 1 (polynomial x^8+x^5+x^4+1). Running all 64 identity bits through the same CRC yields 00h.
- R3: After a bus reset, the next 8 slots form the command byte, received LSB first. The codes are 33h read, 55h match, F0h search, CCh skip and A5h resume.
- R4: Read sends the 64 identity bits in 64 transmit slots. It then raises mem_sel_o and clears the resume flag.
- R5: Match receives 64 bits and compares them with the identity. If all 64 bits agree, the block raises mem_sel_o and sets the resume flag. The first differing bit sends the block idle and clears the flag.
- R6: Search handles each identity bit in three slots: a transmit slot with the true bit, a transmit slot with its complement, and a receive slot for the master's bit. If the master's bit differs from the device bit, the block goes idle and clears the flag. If all 64 bits agree, the block raises mem_sel_o and sets the flag.
- R7: Skip raises mem_sel_o right after the command byte and clears the resume flag.
- R8: Resume raises mem_sel_o and keeps the flag set if the flag was set. If the flag was clear, the block goes idle.
- R9: An unrecognised command sends the block idle until the next bus reset and leaves the flag unchanged. An idle block transmits nothing and ignores slots.
- R10: bus_reset_i at any time restarts command reception and drops mem_sel_o. The resume flag keeps its value across bus resets and changes only on a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| serial_i | input | SERIAL_W | Serial number field of the identity |
| bus_reset_i | input | 1 | One-cycle pulse on a bus reset/presence event |
| slot_i | input | 1 | One-cycle pulse at the end of each time slot |
| rx_bit_i | input | 1 | Bus level sampled in that slot |
| tx_active_o | output | 1 | The next slot is a transmit slot of this layer |
| tx_bit_o | output | 1 | Level to send in the next slot (0 = drive low) |
| mem_sel_o | output | 1 | ROM phase succeeded; the memory layer owns the bus |
| resume_o | output | 1 | Resume flag |

## Verification
The bench builds the block with its defaults: the 48-bit serial field and family code 2Dh, so the identity is the full 64 bits and the CRC byte is real data that matching and search must cover. With these values, a mismatch in the very last (CRC) bit and in the very first (family) bit can both be reached. The bench also walks command sequences that carry the resume flag across bus resets, through an unknown command, and through skip and read, which clear it.

// File: rtl/rom_cmd_pkg.sv
package rom_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH_T,
    ST_SRCH_C,
    ST_SRCH_W,
    ST_SEL
  } rom_state_e;

  localparam int          CMD_W     = 8;
  localparam int          CRC_W     = 8;
  localparam int          FAM_W     = 8;
  localparam logic [7:0]  CMD_READ  = 8'h33;
  localparam logic [7:0]  CMD_MATCH = 8'h55;
  localparam logic [7:0]  CMD_SRCH  = 8'hF0;
  localparam logic [7:0]  CMD_SKIP  = 8'hCC;
  localparam logic [7:0]  CMD_RESUM = 8'hA5;
  localparam logic [7:0]  CRC_POLY  = 8'h8C;  // reflected x^8+x^5+x^4+1

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    logic [CRC_W-1:0] n;
    fb = c[0] ^ b;
    n  = c >> 1;
    if (fb) n = n ^ CRC_POLY;
    return n;
  endfunction

endpackage

// File: rtl/rom_id_crc.sv
module rom_id_crc
  import rom_cmd_pkg::*;
#(
  parameter int         SERIAL_W    = 48,
  parameter logic [7:0] FAMILY_CODE = 8'h2D,
  localparam int        BODY_W      = FAM_W + SERIAL_W,
  localparam int        ID_W        = BODY_W + CRC_W
) (
  input  logic [SERIAL_W-1:0] serial_i,
  output logic [ID_W-1:0]     id_o
);

  logic [BODY_W-1:0] body;
  logic [CRC_W-1:0]  crc;

  assign body = {serial_i, FAMILY_CODE};

  always_comb begin
    crc = '0;
    for (int i = 0; i < BODY_W; i++) crc = crc_step(crc, body[i]);
  end

  assign id_o = {crc, body};

endmodule

// File: rtl/rom_slot_cnt.sv
module rom_slot_cnt #(
  parameter int CNT_W = 6,
  parameter int CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             shift_i,
  input  logic             rx_bit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CMD_W-1:0] cmd_nxt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] cmd_q;

  assign cmd_nxt_o = {rx_bit_i, cmd_q[CMD_W-1:1]};  // LSB first
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmd_q <= '0;
    end else begin
      if (clr_i)      cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
      if (shift_i)    cmd_q <= cmd_nxt_o;
    end
  end

endmodule

// File: rtl/rom_cmd_fsm.sv
module rom_cmd_fsm
  import rom_cmd_pkg::*;
#(
  parameter int  ID_W  = 64,
  localparam int CNT_W = $clog2(ID_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_reset_i,
  input  logic             slot_i,
  input  logic             rx_bit_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CMD_W-1:0] cmd_nxt_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             cmd_shift_o,
  output logic             tx_active_o,
  output logic             tx_bit_o,
  output logic             mem_sel_o,
  output logic             resume_o
);

  rom_state_e state_q, state_d;
  logic       flag_q, flag_d;
  logic       id_bit, last_bit, last_cmd;

  assign id_bit   = id_i[cnt_i];
  assign last_bit = (cnt_i == CNT_W'(ID_W - 1));
  assign last_cmd = (cnt_i == CNT_W'(CMD_W - 1));

  always_comb begin
    state_d     = state_q;
    flag_d      = flag_q;
    cnt_clr_o   = 1'b0;
    cnt_inc_o   = 1'b0;
    cmd_shift_o = 1'b0;
    if (bus_reset_i) begin
      state_d   = ST_CMD;
      cnt_clr_o = 1'b1;
    end else if (slot_i) begin
      unique case (state_q)
        ST_CMD: begin
          cmd_shift_o = 1'b1;
          if (last_cmd) begin
            cnt_clr_o = 1'b1;
            unique case (cmd_nxt_i)
              CMD_READ:  begin state_d = ST_READ; flag_d = 1'b0; end
              CMD_MATCH: state_d = ST_MATCH;
              CMD_SRCH:  state_d = ST_SRCH_T;
              CMD_SKIP:  begin state_d = ST_SEL; flag_d = 1'b0; end
              CMD_RESUM: state_d = flag_q ? ST_SEL : ST_IDLE;
              default:   state_d = ST_IDLE;
            endcase
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        ST_READ: begin
          if (last_bit) state_d = ST_SEL;
          else          cnt_inc_o = 1'b1;
        end
        ST_MATCH: begin
          if (rx_bit_i != id_bit) begin
            state_d = ST_IDLE;
            flag_d  = 1'b0;
          end else if (last_bit) begin
            state_d = ST_SEL;
            flag_d  = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        ST_SRCH_T: state_d = ST_SRCH_C;
        ST_SRCH_C: state_d = ST_SRCH_W;
        ST_SRCH_W: begin
          if (rx_bit_i != id_bit) begin
            state_d = ST_IDLE;
            flag_d  = 1'b0;
          end else if (last_bit) begin
            state_d = ST_SEL;
            flag_d  = 1'b1;
          end else begin
            state_d   = ST_SRCH_T;
            cnt_inc_o = 1'b1;
          end
        end
        default: ;  // idle or selected: slots belong to nobody / memory layer
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    tx_active_o = 1'b0;
    tx_bit_o    = 1'b1;
    unique case (state_q)
      ST_READ, ST_SRCH_T: begin tx_active_o = 1'b1; tx_bit_o = id_bit;  end
      ST_SRCH_C:          begin tx_active_o = 1'b1; tx_bit_o = ~id_bit; end
      default: ;
    endcase
  end

  assign mem_sel_o = (state_q == ST_SEL);
  assign resume_o  = flag_q;

endmodule

// File: rtl/rom_cmd_layer.sv
module rom_cmd_layer
  import rom_cmd_pkg::*;
#(
  parameter int         SERIAL_W    = 48,
  parameter logic [7:0] FAMILY_CODE = 8'h2D,
  localparam int        ID_W        = FAM_W + SERIAL_W + CRC_W,
  localparam int        CNT_W       = $clog2(ID_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SERIAL_W-1:0] serial_i,
  input  logic                bus_reset_i,
  input  logic                slot_i,
  input  logic                rx_bit_i,
  output logic                tx_active_o,
  output logic                tx_bit_o,
  output logic                mem_sel_o,
  output logic                resume_o
);

  logic [ID_W-1:0]  id;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] cmd_nxt;
  logic             cnt_clr, cnt_inc, cmd_shift;

  rom_id_crc #(
    .SERIAL_W    (SERIAL_W),
    .FAMILY_CODE (FAMILY_CODE)
  ) u_id (
    .serial_i (serial_i),
    .id_o     (id)
  );

  rom_slot_cnt #(
    .CNT_W (CNT_W),
    .CMD_W (CMD_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cnt_clr),
    .inc_i     (cnt_inc),
    .shift_i   (cmd_shift),
    .rx_bit_i  (rx_bit_i),
    .cnt_o     (cnt),
    .cmd_nxt_o (cmd_nxt)
  );

  rom_cmd_fsm #(
    .ID_W (ID_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .slot_i      (slot_i),
    .rx_bit_i    (rx_bit_i),
    .id_i        (id),
    .cnt_i       (cnt),
    .cmd_nxt_i   (cmd_nxt),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc),
    .cmd_shift_o (cmd_shift),
    .tx_active_o (tx_active_o),
    .tx_bit_o    (tx_bit_o),
    .mem_sel_o   (mem_sel_o),
    .resume_o    (resume_o)
  );

endmodule

// File: rtl/rom_cmd_layer_chk.sv
module rom_cmd_layer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_reset_i,
  input logic slot_i,
  input logic tx_active_o,
  input logic mem_sel_o,
  input logic resume_o
);

  assert_bus_reset_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (!mem_sel_o && !tx_active_o));

  assert_flag_slot_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> $stable(resume_o));

  assert_sel_from_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_sel_o) |-> $past(slot_i));

  assert_sel_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_sel_o && !bus_reset_i) |=> mem_sel_o);

  assert_flag_on_select_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resume_o) |-> mem_sel_o);

  assert_sel_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_sel_o) |-> $past(bus_reset_i));

endmodule

bind rom_cmd_layer rom_cmd_layer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_reset_i (bus_reset_i),
  .slot_i      (slot_i),
  .tx_active_o (tx_active_o),
  .mem_sel_o   (mem_sel_o),
  .resume_o    (resume_o)
);

// File: tb/rom_cmd_layer_tb_top.sv
module rom_cmd_layer_tb_top;

  localparam logic [47:0] SERIAL = 48'h00A1_B2C3_D4E5;
  localparam int          NVEC   = 9;
  // {command, expected mem_sel, expected flag}
  localparam logic [9:0] VEC [NVEC] = '{
    {8'hCC, 1'b1, 1'b0},  // R7 skip
    {8'hA5, 1'b0, 1'b0},  // R8 resume, flag clear
    {8'h55, 1'b1, 1'b1},  // R5 match
    {8'hA5, 1'b1, 1'b1},  // R8 resume, flag set
    {8'h3C, 1'b0, 1'b1},  // R9 unknown
    {8'hA5, 1'b1, 1'b1},  // R8 flag kept
    {8'h33, 1'b1, 1'b0},  // R4 read
    {8'hF0, 1'b1, 1'b1},  // R6 search
    {8'hCC, 1'b1, 1'b0}   // R7 skip
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_reset_i = 1'b0;
  logic        slot_i = 1'b0;
  logic        rx_bit_i = 1'b1;
  logic        tx_active_o, tx_bit_o, mem_sel_o, resume_o;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [63:0] exp_id;

  always #5 clk_i = ~clk_i;

  rom_cmd_layer dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .serial_i    (SERIAL),
    .bus_reset_i (bus_reset_i),
    .slot_i      (slot_i),
    .rx_bit_i    (rx_bit_i),
    .tx_active_o (tx_active_o),
    .tx_bit_o    (tx_bit_o),
    .mem_sel_o   (mem_sel_o),
    .resume_o    (resume_o)
  );

  function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 0; i < n; i++) begin
      fb = c[0] ^ v[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    @(negedge clk_i);
    slot_i   = 1'b1;
    rx_bit_i = b;
    @(negedge clk_i);
    slot_i   = 1'b0;
    rx_bit_i = 1'b1;
  endtask

  task automatic bus_rst();
    @(negedge clk_i);
    bus_reset_i = 1'b1;
    @(negedge clk_i);
    bus_reset_i = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    bus_rst();
    for (int i = 0; i < 8; i++) slot(c[i]);
  endtask

  task automatic do_read(output logic [63:0] got, output logic all_act);
    all_act = 1'b1;
    for (int i = 0; i < 64; i++) begin
      all_act = all_act & tx_active_o;
      got[i]  = tx_bit_o;
      slot(1'b1);
    end
  endtask

  task automatic do_match(input logic [63:0] v);
    for (int i = 0; i < 64; i++) slot(v[i]);
  endtask

  task automatic do_search(input int flip_at, output logic ok);
    ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      logic t, c;
      ok = ok & tx_active_o;
      t  = tx_bit_o;
      slot(1'b1);
      ok = ok & tx_active_o;
      c  = tx_bit_o;
      slot(1'b1);
      ok = ok & (t == exp_id[i]) & (c == ~exp_id[i]);
      slot(i == flip_at ? ~exp_id[i] : exp_id[i]);
      if (i == flip_at) break;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] got;
    logic        ok;
    exp_id[7:0]   = 8'h2D;
    exp_id[55:8]  = SERIAL;
    exp_id[63:56] = 8'h00;
    exp_id[63:56] = ref_crc(exp_id, 56);

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 reset outputs", {tx_active_o, tx_bit_o, mem_sel_o, resume_o}, 64'b0100);
    for (int i = 0; i < 8; i++) slot(8'hCC >> i);
    chk("R1 slots ignored before bus reset", {tx_active_o, mem_sel_o}, 64'b00);
    // R2 CRC residue
    chk("R2 crc over full identity", ref_crc(exp_id, 64), 64'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] c;
      c = VEC[v][9:2];
      send_cmd(c);
      if (c == 8'h33) begin
        do_read(got, ok);
        chk("R4 read transmit slots", ok, 1'b1);
        chk("R2 R4 identity bits LSB first", got, exp_id);
      end else if (c == 8'h55) begin
        do_match(exp_id);
      end else if (c == 8'hF0) begin
        do_search(64, ok);
        chk("R6 search true/complement slots", ok, 1'b1);
      end
      chk($sformatf("R3 vec %0d cmd %h mem_sel", v, c), mem_sel_o, VEC[v][1]);
      chk($sformatf("R3 vec %0d cmd %h flag", v, c), resume_o, VEC[v][0]);
    end

    // R10 bus reset while selected, flag retained
    send_cmd(8'h55);
    do_match(exp_id);
    bus_rst();
    chk("R10 sel dropped, flag kept", {mem_sel_o, resume_o}, 64'b01);

    // R5 mismatch on last (CRC) bit
    send_cmd(8'h55);
    do_match(exp_id ^ (64'h1 << 63));
    chk("R5 mismatch last bit", {mem_sel_o, resume_o, tx_active_o}, 64'b000);
    slot(1'b0);
    chk("R9 idle ignores slots", {mem_sel_o, tx_active_o}, 64'b00);

    // R6 search loses at bit 0
    send_cmd(8'h55);
    do_match(exp_id);
    send_cmd(8'hF0);
    do_search(0, ok);
    chk("R6 search bit0 slots", ok, 1'b1);
    chk("R6 search lost", {mem_sel_o, resume_o, tx_active_o}, 64'b000);

    // R10 bus reset mid-read restarts command reception
    send_cmd(8'h33);
    for (int i = 0; i < 10; i++) slot(1'b1);
    bus_rst();
    chk("R10 reset mid-read", {tx_active_o, mem_sel_o}, 64'b00);
    for (int i = 0; i < 8; i++) slot(8'hCC >> i);
    chk("R10 command after mid-read reset", mem_sel_o, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule